// File: doc/BRIEF.md
# Serial Byte Link with Clear-to-Send Flow Control

This block is a full-duplex asynchronous serial port that moves one byte per frame in each direction at the same time. A frame is one low start bit, the data bits sent least significant bit first, and one or more high stop bits. The line rests high between frames. The host side offers a transmit byte with a valid/ready handshake. Each received byte comes back on a parallel bus, marked by a one-cycle valid pulse and a framing-error flag.

Flow control runs in both directions over active-high clear-to-send wires. The incoming wire `cts_in` gates the transmitter. When it falls, the frame on the line still runs through its stop bits, and no further start bit is sent until the wire rises again. The outgoing wire `cts_out` falls on the cycle a received byte is delivered. It stays low until the consumer acknowledges the byte, which tells the far end to hold off. Clock rate, baud rate, data bits and stop bits are fixed by parameters when the block is built. The defaults are 24 MHz and 500 kbaud, which gives 48 clocks per bit.

Both directions share one bit-timer design. The transmit engine has the states TX_IDLE, TX_START, TX_DATA and TX_STOP. TX_IDLE goes to TX_START when a byte is accepted. Each state moves on to the next after a full bit period. TX_DATA moves on after its last data bit, and TX_STOP returns to TX_IDLE after its last stop bit. The receive engine has the states RX_IDLE, RX_START, RX_DATA and RX_STOP. A falling edge in RX_IDLE leads to RX_START. At mid-start, a low line leads to RX_DATA and a high line is a glitch that returns to RX_IDLE. RX_DATA goes to RX_STOP after its last sample. RX_STOP returns to RX_IDLE and delivers the byte.

Top module: `uart_cts_core`

## Requirements
- R1: While reset is asserted and just after it: `txd` is 1, `tx_ready` is 0, `rx_valid` is 0, `rx_frame_err` is 0 and `cts_out` is 1.
- R2: A transmitted frame is one 0 start bit, then DATA_BITS data bits least significant first, then STOP_BITS stop bits at 1. The line is 1 when idle.
- R3: Every transmitted bit lasts exactly CLKS_PER_BIT = CLK_HZ/BAUD clocks. The leading low run of a frame is 48 × (1 + trailing zero bits of the byte) clocks, so byte 0x00 holds `txd` low for exactly 432 clocks.
- R4: A byte is accepted on a rising edge where `tx_valid` and `tx_ready` are both 1. `txd` is 0 in the cycle after that edge, and `tx_ready` is 0 until the frame has ended.
- R5: `tx_ready` is 1 only when the transmitter is idle and `cts_in`, after two synchronising flops, is 1.
- R6: If `cts_in` falls during a frame, that frame finishes with its stop bit at full length. No start bit is sent while `cts_in` stays low, even if a byte is offered.
- R7: The receiver starts on a falling edge of the synchronised `rxd` and samples each bit at mid-period. It places the byte on `rx_data` with `rx_valid` high for exactly one cycle.
- R8: `rx_frame_err` is set with `rx_valid` when the sampled stop bit is 0, and cleared when it is 1.
- R9: After a frame, a new reception needs a 1-to-0 transition. A line held at 0 after a bad stop bit produces no further deliveries.
- R10: `cts_out` is 0 from the delivery cycle until the cycle after `rx_ack` is seen. If the acknowledge and a delivery fall in the same cycle, the delivery wins and `cts_out` is 0 in that cycle.
- R11: A low pulse on `rxd` shorter than half a bit period is rejected as a glitch. No byte is delivered.
- R12: Transmit and receive run at the same time. A frame looped from `txd` to `rxd` is received while it is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | DATA_BITS | Byte offered for transmission |
| tx_valid | input | 1 | Offer strobe for `tx_data` |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output line |
| cts_in | input | 1 | Far end clear to send, active high |
| rxd | input | 1 | Serial input line |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-cycle delivery pulse |
| rx_frame_err | output | 1 | Stop bit of the delivered byte was low |
| rx_ack | input | 1 | Consumer has taken the held byte |
| cts_out | output | 1 | This end can accept a byte, active high |

## Verification
Two collisions are provoked deliberately. The first is full duplex: `txd` is looped to `rxd`, so each byte in the vector table is decoded off the line by the bench while the receiver assembles the same frame. Bit values, leading low run length and the delivered byte are all compared with the table. The second is an acknowledge landing on the delivery cycle: `rx_ack` is held high through whole receptions, and a monitor requires `cts_out` to be low on every cycle where `rx_valid` is high. That shows the delivery takes priority over the same-cycle acknowledge.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/uart_sync2.sv
module uart_sync2 #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            sync_q <= RESET_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
    parameter int CLKS_PER_BIT = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic half,
    output logic tick
);

    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] END_V = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] MID_V = CW'(CLKS_PER_BIT / 2 - 1);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == END_V);

    // Wraps after exactly CLKS_PER_BIT counts: 0 .. CLKS_PER_BIT-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = half ? (cnt_q == MID_V) : at_end;

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_cts_pkg::*;
#(
    parameter int DATA_BITS    = 8,
    parameter int STOP_BITS    = 1,
    parameter int CLKS_PER_BIT = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cts_ok,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic                 txd
);

    localparam int IDX_MAX = (DATA_BITS > STOP_BITS) ? DATA_BITS : STOP_BITS;
    localparam int BW      = $clog2(IDX_MAX + 1);
    localparam logic [BW-1:0] LAST_DATA = BW'(DATA_BITS - 1);
    localparam logic [BW-1:0] LAST_STOP = BW'(STOP_BITS - 1);

    tx_state_e            state_q, state_d;
    logic [DATA_BITS-1:0] shreg_q;
    logic [BW-1:0]        bit_q;
    logic                 tick;
    logic                 accept;

    uart_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == TX_IDLE),
        .half  (1'b0),
        .tick  (tick)
    );

    assign accept = (state_q == TX_IDLE) && cts_ok && tx_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (accept)                        state_d = TX_START;
            TX_START: if (tick)                          state_d = TX_DATA;
            TX_DATA:  if (tick && (bit_q == LAST_DATA))  state_d = TX_STOP;
            TX_STOP:  if (tick && (bit_q == LAST_STOP))  state_d = TX_IDLE;
            default:                                     state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // shift register and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    bit_q <= '0;
                    if (accept) shreg_q <= tx_data;
                end
                TX_START: bit_q <= '0;
                TX_DATA: if (tick) begin
                    shreg_q <= shreg_q >> 1;
                    bit_q   <= (bit_q == LAST_DATA) ? '0 : bit_q + 1'b1;
                end
                TX_STOP: if (tick) bit_q <= bit_q + 1'b1;
                default: bit_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_ready = 1'b0;
        txd      = 1'b1;
        unique case (state_q)
            TX_IDLE:  tx_ready = cts_ok;
            TX_START: txd      = 1'b0;
            TX_DATA:  txd      = shreg_q[0];
            TX_STOP:  txd      = 1'b1;
            default:  txd      = 1'b1;
        endcase
    end

    // R4
    tx_busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && !txd));

    // R6
    start_needs_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_START && $past(state_q) == TX_IDLE) |-> $past(cts_ok));

    // R3
    bit_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_IDLE && !tick) |=> $stable(txd));

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_cts_pkg::*;
#(
    parameter int DATA_BITS    = 8,
    parameter int CLKS_PER_BIT = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxs,
    input  logic                 rx_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err,
    output logic                 cts_out
);

    localparam int BW = $clog2(DATA_BITS + 1);
    localparam logic [BW-1:0] LAST_DATA = BW'(DATA_BITS - 1);

    rx_state_e            state_q, state_d;
    logic [DATA_BITS-1:0] shreg_q;
    logic [DATA_BITS-1:0] data_q;
    logic [BW-1:0]        bit_q;
    logic                 prev_q;
    logic                 valid_q;
    logic                 err_q;
    logic                 held_q;
    logic                 tick;
    logic                 fall;
    logic                 deliver;

    assign fall    = prev_q && !rxs;
    assign deliver = (state_q == RX_STOP) && tick;

    uart_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear ((state_q == RX_IDLE) || ((state_q == RX_START) && tick)),
        .half  (state_q == RX_START),
        .tick  (tick)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (fall) state_d = RX_START;
            RX_START: if (tick) state_d = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && (bit_q == LAST_DATA)) state_d = RX_STOP;
            RX_STOP:  if (tick) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // sampling datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            shreg_q <= '0;
            bit_q   <= '0;
        end else begin
            prev_q <= rxs;
            if (state_q == RX_DATA && tick) begin
                shreg_q <= {rxs, shreg_q[DATA_BITS-1:1]};
                bit_q   <= (bit_q == LAST_DATA) ? '0 : bit_q + 1'b1;
            end else if (state_q == RX_IDLE) begin
                bit_q <= '0;
            end
        end
    end

    // delivery and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            valid_q <= deliver;
            if (deliver) begin
                data_q <= shreg_q;
                err_q  <= !rxs;
                held_q <= 1'b1;
            end else if (rx_ack) begin
                held_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        rx_data      = data_q;
        rx_valid     = valid_q;
        rx_frame_err = err_q;
        cts_out      = !held_q;
    end

    // R7
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10
    cts_low_on_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !cts_out);

    // R8
    frame_err_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_frame_err) |-> rx_valid);

    // R9
    start_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && $past(state_q) == RX_IDLE) |-> !$past(rxs, 2) == 1'b0);

endmodule

// File: rtl/uart_cts_core.sv
module uart_cts_core #(
    parameter int CLK_HZ    = 24_000_000,
    parameter int BAUD      = 500_000,
    parameter int DATA_BITS = 8,
    parameter int STOP_BITS = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic                 txd,
    input  logic                 cts_in,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err,
    input  logic                 rx_ack,
    output logic                 cts_out
);

    localparam int CLKS_PER_BIT = CLK_HZ / BAUD;

    logic cts_ok;
    logic rxs;

    uart_sync2 #(.RESET_VAL(1'b0)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_in),
        .q     (cts_ok)
    );

    uart_sync2 #(.RESET_VAL(1'b1)) u_rx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rxs)
    );

    uart_tx_fsm #(
        .DATA_BITS    (DATA_BITS),
        .STOP_BITS    (STOP_BITS),
        .CLKS_PER_BIT (CLKS_PER_BIT)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_ok   (cts_ok),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    uart_rx_fsm #(
        .DATA_BITS    (DATA_BITS),
        .CLKS_PER_BIT (CLKS_PER_BIT)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxs          (rxs),
        .rx_ack       (rx_ack),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err),
        .cts_out      (cts_out)
    );

    // R5
    ready_needs_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> cts_ok);

endmodule

// File: tb/tb_uart_cts_core.sv
module tb_uart_cts_core;

    localparam int CPB = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       cts_in = 1'b1;
    logic       rxd;
    logic       rxd_drv = 1'b1;
    logic       loop_en = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;
    logic       rx_ack = 1'b0;
    logic       cts_out;

    int checks = 0;
    int fails  = 0;
    int rx_count = 0;
    logic [7:0] last_data = 8'h00;
    logic       last_err = 1'b0;
    logic       prev_valid = 1'b0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    assign rxd = loop_en ? txd : rxd_drv;

    uart_cts_core dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .txd          (txd),
        .cts_in       (cts_in),
        .rxd          (rxd),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err),
        .rx_ack       (rx_ack),
        .cts_out      (cts_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // delivery monitor: one-cycle pulse and cts_out low on delivery
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_count++;
            last_data = rx_data;
            last_err  = rx_frame_err;
            check(!prev_valid, "R7 pulse width", 1, 0);
            check(cts_out == 1'b0, "R10 cts_out on delivery", cts_out, 0);
        end
        prev_valid = rx_valid;
    end

    // {byte, leading low run in bit periods}
    localparam logic [11:0] VEC [8] = '{
        {8'h55, 4'd1}, {8'hAA, 4'd2}, {8'h01, 4'd1}, {8'h80, 4'd8},
        {8'hC3, 4'd1}, {8'h7E, 4'd2}, {8'hFF, 4'd1}, {8'h00, 4'd9}
    };

    task automatic send(input logic [7:0] d);
        int t;
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        t = 0;
        while (!tx_ready && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, "R4 handshake", t, 0);
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // starts at the first negedge after acceptance
    task automatic capture(output logic [9:0] bits, output int run);
        bit in_run;
        bits = '0;
        run = 0;
        in_run = 1'b1;
        for (int k = 0; k < 10 * CPB; k++) begin
            if (k > 0) @(negedge clk);
            if (in_run && txd == 1'b0) run++;
            else in_run = 1'b0;
            if ((k % CPB) == CPB / 2) bits[k / CPB] = txd;
        end
    endtask

    task automatic wait_rx(input int prev, input string req);
        int t;
        t = 0;
        while (rx_count == prev && t < 40 * CPB) begin
            @(negedge clk);
            t++;
        end
        check(rx_count == prev + 1, req, rx_count - prev, 1);
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
    endtask

    task automatic drive_frame(input logic [7:0] d, input logic stop);
        rxd_drv = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            rxd_drv = d[b];
            repeat (CPB) @(negedge clk);
        end
        rxd_drv = stop;
        repeat (CPB) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] bits;
        int run;
        int n;
        bit stayed;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
        check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        check(rx_frame_err == 1'b0, "R1 rx_frame_err", rx_frame_err, 0);
        check(cts_out == 1'b1, "R1 cts_out", cts_out, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b0, "R5 sync latency", tx_ready, 0);
        repeat (2) @(negedge clk);
        check(tx_ready == 1'b1, "R5 ready after sync", tx_ready, 1);

        // vector table, loopback: R2 R3 R7 R12
        for (int i = 0; i < 8; i++) begin
            n = rx_count;
            send(VEC[i][11:4]);
            capture(bits, run);
            check(bits[0] == 1'b0, "R2 start bit", bits[0], 0);
            check(bits[8:1] == VEC[i][11:4], "R2 data bits", bits[8:1], VEC[i][11:4]);
            check(bits[9] == 1'b1, "R2 stop bit", bits[9], 1);
            check(run == CPB * int'(VEC[i][3:0]), "R3 low run", run, CPB * int'(VEC[i][3:0]));
            wait_rx(n, "R12 loopback delivery");
            check(last_data == VEC[i][11:4], "R7 rx_data", last_data, VEC[i][11:4]);
            check(last_err == 1'b0, "R8 err clear", last_err, 0);
            check(cts_out == 1'b0, "R10 held", cts_out, 0);
            ack_pulse();
            check(cts_out == 1'b1, "R10 released", cts_out, 1);
        end

        // R6 cts drop mid-frame; R10 ack held across delivery
        rx_ack = 1'b1;
        n = rx_count;
        send(8'h00);
        run = 1;
        for (int k = 1; k < 100; k++) begin
            @(negedge clk);
            if (txd == 1'b0) run++;
        end
        cts_in = 1'b0;
        @(negedge clk);
        while (txd == 1'b0 && run < 2000) begin
            run++;
            @(negedge clk);
        end
        check(run == 9 * CPB, "R6 frame completes", run, 9 * CPB);
        stayed = 1'b1;
        for (int k = 0; k < CPB - 1; k++) begin
            if (txd != 1'b1) stayed = 1'b0;
            @(negedge clk);
        end
        check(stayed, "R6 stop bit full", stayed, 1);
        tx_data  = 8'h3C;
        tx_valid = 1'b1;
        stayed = 1'b1;
        for (int k = 0; k < 8 * CPB; k++) begin
            @(negedge clk);
            if (txd != 1'b1 || tx_ready != 1'b0) stayed = 1'b0;
        end
        check(stayed, "R6 no start while cts low", stayed, 1);
        check(tx_ready == 1'b0, "R5 ready low with cts low", tx_ready, 0);
        tx_valid = 1'b0;
        cts_in = 1'b1;
        send(8'h3C);
        capture(bits, run);
        check(bits[8:1] == 8'h3C, "R6 resumes", bits[8:1], 8'h3C);
        repeat (4 * CPB) @(negedge clk);
        check(rx_count == n + 2, "R12 both delivered", rx_count - n, 2);
        check(cts_out == 1'b1, "R10 ack released", cts_out, 1);
        rx_ack = 1'b0;

        // R8 R9 framing error with line held low
        loop_en = 1'b0;
        rxd_drv = 1'b1;
        repeat (CPB) @(negedge clk);
        n = rx_count;
        drive_frame(8'hA5, 1'b0);
        repeat (12 * CPB) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (4 * CPB) @(negedge clk);
        check(rx_count == n + 1, "R9 single delivery", rx_count - n, 1);
        check(last_err == 1'b1, "R8 err set", last_err, 1);
        check(last_data == 8'hA5, "R7 data with err", last_data, 8'hA5);
        ack_pulse();

        // R11 glitch
        n = rx_count;
        rxd_drv = 1'b0;
        repeat (CPB / 4) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (12 * CPB) @(negedge clk);
        check(rx_count == n, "R11 glitch rejected", rx_count - n, 0);
        check(cts_out == 1'b1, "R11 cts_out unaffected", cts_out, 1);

        // R8 good frame clears err
        drive_frame(8'h96, 1'b1);
        wait_rx(n, "R7 directed delivery");
        check(last_data == 8'h96, "R7 directed data", last_data, 8'h96);
        check(last_err == 1'b0, "R8 err cleared", last_err, 0);
        check(cts_out == 1'b0, "R10 held directed", cts_out, 0);
        ack_pulse();
        check(cts_out == 1'b1, "R10 released directed", cts_out, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule